// File: doc/BRIEF.md
# SPI-NOR Flash Command Sequencer

This block runs one serial-flash transaction at a time on a single-lane SPI bus with up to four chip-select lines. A register front end hands it a decoded descriptor as four words (address, phase format, data byte count and a launch word carrying the opcode, chip-select index and mode bits) together with a one-cycle launch strobe. The sequencer first toggles the chosen chip-select inactive and then active. It then shifts out the opcode, the address bytes and the dummy bytes, and finally either streams data words out to the flash or collects words from it.

Data moves in 32-bit words, four bytes to a word, least significant byte first on the wire. A write takes each word from the front end through a valid/ready handshake. A read hands each assembled word back with a one-cycle valid pulse. Chip-select stays low across the whole data phase and is released once the remaining byte count reaches zero. A status-poll mode instead resends a read-status opcode and samples the returned byte, repeating until a chosen busy bit reads zero. The last sampled byte stays visible on an output.

The serial clock runs at half the system clock in SPI mode 0.

Top module: `spi_nor_seq`

## Requirements
- R1: After reset every `cs_n` line is high, `sck` is low, and `busy`, `done_flag`, `wr_ready`, `rd_valid` and `status_byte` are all zero.
- R2: A `launch` pulse taken while `busy` is low raises `busy` on the next edge. Only the line picked by launch-word bits [9:8] goes low. A `launch` that arrives while `busy` is high is ignored: it changes no line, no byte and no later state.
- R3: The opcode (launch-word bits [31:24]) is sent as many times as format-word bits [25:24] say, with any value above 2 treated as 2.
- R4: Address bytes come from `desc_addr`, most significant of the selected bytes first. Their number is format-word bits [2:0], with any value above 4 treated as 4.
- R5: After the address, the block sends as many 0x00 bytes as format-word bits [23:16] divided by 8 (rounded down).
- R6: The bus uses SPI mode 0 with bits MSB first. `sck` is low whenever `busy` is low, and each high phase of `sck` lasts exactly one system clock.
- R7: When launch-word bits [2:1] equal 2'b10, the block sends the opcode and then reads one byte, which it places on `status_byte`. It repeats this while bit `poll_bit` of that byte is 1. If launch-word bit 3 is set, it stops after the first read.
- R8: When the byte count `desc_len` is zero after the command phases, chip-select is released and `busy` falls on the same edge, with no data bytes sent.
- R9: When launch-word bit 1 is 1 (and the mode is not status-poll), each data word is taken from `wr_word` while `wr_ready` and `wr_valid` are both high. Its four bytes are sent least significant first.
- R10: When launch-word bit 1 is 0, each group of four received bytes is presented on `rd_word`, with the first received byte in bits [7:0], during a one-cycle `rd_valid` pulse.
- R11: Each word moved lowers the remaining count by 4, or sets it to zero if fewer than 4 bytes remain. So a count of N moves ceil(N/4) words.
- R12: At release, `done_flag` is set if launch-word bit 0 is 1. It stays set until a `done_clr` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | One-cycle start strobe |
| desc_addr | input | 32 | Flash address word |
| desc_fmt | input | 32 | Phase format: opcode repeat, dummy cycles, address length |
| desc_len | input | CNT_W (32) | Data byte count |
| desc_go | input | 32 | Opcode, chip-select index, single-read, mode and flag-enable bits |
| poll_bit | input | 3 | Busy-bit position tested in status-poll mode |
| done_clr | input | 1 | Clears the completion flag |
| wr_valid | input | 1 | Write word offered |
| wr_word | input | DATA_W (32) | Write data word |
| wr_ready | output | 1 | Sequencer waiting for a write word |
| rd_valid | output | 1 | Read word present (one cycle) |
| rd_word | output | DATA_W (32) | Assembled read word |
| status_byte | output | 8 | Last status byte read by polling |
| done_flag | output | 1 | Sticky completion flag |
| busy | output | 1 | Transaction in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | NUM_CS (4) | Active-low chip-selects |

## Verification
The bench builds the block with its defaults: four chip-select lines, 32-bit words and a 32-bit byte count. This makes every select index reachable, and it lets an oversized address-length or opcode-repeat code hit its cap. Byte counts from 0 to 16 include the values that are not multiples of four, which exercises the clamp on the last word. Dummy fields up to 63 are used, so the divide-by-eight truncation is exercised. A flash model behind the bus logs every byte and returns scripted status bytes, so the multi-round poll, the single-read exit and an ignored mid-transaction launch are all observed at the pins.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CSOFF,
        ST_INSTR,
        ST_ADDR,
        ST_DUMMY,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_DCHK,
        ST_WRWAIT,
        ST_XFER
    } seq_st_e;

    // Field positions the front end decodes against
    localparam int GO_OP_LSB   = 24;
    localparam int GO_CS_LSB   = 8;
    localparam int GO_SINGLE   = 3;
    localparam int GO_WRITE    = 1;
    localparam int GO_IRQ      = 0;
    localparam int FMT_IL_LSB  = 24;
    localparam int FMT_DC_LSB  = 19;   // dummy cycles / 8
    localparam int MAX_ILEN    = 2;
    localparam int MAX_ALEN    = 4;

endpackage

// File: rtl/spi_nor_shifter.sv
module spi_nor_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int BITS  = 8;
    localparam int BCW   = $clog2(BITS);

    typedef struct packed {
        logic           act;
        logic           ph;
        logic [BCW-1:0] cnt;
        logic [7:0]     sh;
        logic [7:0]     rx;
        logic           sck;
        logic           done;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.act) begin
            if (start) begin
                sh_d.act = 1'b1;
                sh_d.ph  = 1'b0;
                sh_d.cnt = '0;
                sh_d.sh  = tx;
                sh_d.sck = 1'b0;
            end
        end else if (!sh_q.ph) begin
            sh_d.sck = 1'b1;
            sh_d.rx  = {sh_q.rx[6:0], miso};
            sh_d.ph  = 1'b1;
        end else begin
            sh_d.sck = 1'b0;
            sh_d.ph  = 1'b0;
            if (sh_q.cnt == BCW'(BITS - 1)) begin
                sh_d.act  = 1'b0;
                sh_d.done = 1'b1;
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
                sh_d.sh  = {sh_q.sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck  = sh_q.sck;
    assign mosi = sh_q.sh[7];
    assign done = sh_q.done;
    assign rx   = sh_q.rx;

    // R6: clock idles low outside a byte
    p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_q.act |-> !sh_q.sck);
    // R6: sequencer never restarts a byte in flight
    p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !sh_q.act);
    // R6: high phase lasts one clock
    p_sck_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.sck |=> !sh_q.sck);

endmodule

// File: rtl/spi_nor_cs_decode.sv
module spi_nor_cs_decode #(
    parameter int NUM_CS = 4,
    localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic           act,
    input  logic [CSW-1:0] sel,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = !(act && (sel == CSW'(i)));
    end
endmodule

// File: rtl/spi_nor_sequencer.sv
module spi_nor_sequencer
    import spi_nor_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BYTES = DATA_W / 8,
    localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [31:0]       desc_addr,
    input  logic [31:0]       desc_fmt,
    input  logic [CNT_W-1:0]  desc_len,
    input  logic [31:0]       desc_go,
    input  logic [2:0]        poll_bit,
    input  logic              done_clr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_word,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word,
    output logic [7:0]        status_byte,
    output logic              done_flag,
    output logic              busy,
    output logic              cs_act,
    output logic [CSW-1:0]    cs_sel,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx
);
    typedef struct packed {
        seq_st_e           st;
        logic [CSW-1:0]    sel;
        logic [7:0]        op;
        logic [1:0]        icnt;
        logic [2:0]        acnt;
        logic [4:0]        dcnt;
        logic [31:0]       addr;
        logic [CNT_W-1:0]  rem;
        logic              wr;
        logic              poll;
        logic              single;
        logic              irq;
        logic [2:0]        pbit;
        logic [DATA_W-1:0] word;
        logic [BW-1:0]     bidx;
        logic              inflight;
        logic [7:0]        status;
        logic              done;
        logic              rdv;
    } seq_t;

    seq_t sq_d, sq_q;

    logic unused_desc;
    assign unused_desc = ^{desc_fmt[31:26], desc_fmt[18:3], desc_go[23:10], desc_go[7:4]};

    function automatic seq_st_e first_phase(logic [1:0] i, logic [2:0] a, logic [4:0] d);
        if (i != 2'd0)      return ST_INSTR;
        else if (a != 3'd0) return ST_ADDR;
        else if (d != 5'd0) return ST_DUMMY;
        else                return ST_DCHK;
    endfunction

    logic        byte_st;
    logic        fin;
    logic [31:0] addr_sh;
    logic [1:0]  il_raw;
    logic [2:0]  al_raw;

    assign il_raw  = desc_fmt[FMT_IL_LSB +: 2];
    assign al_raw  = desc_fmt[2:0];
    assign addr_sh = sq_q.addr >> {sq_q.acnt - 3'd1, 3'b000};
    assign byte_st = (sq_q.st == ST_INSTR) || (sq_q.st == ST_ADDR) ||
                     (sq_q.st == ST_DUMMY) || (sq_q.st == ST_POLL_OP) ||
                     (sq_q.st == ST_POLL_RD) || (sq_q.st == ST_XFER);
    assign fin     = sq_q.inflight && sh_done;

    always_comb begin
        sq_d     = sq_q;
        sq_d.rdv = 1'b0;
        sh_start = 1'b0;
        if (done_clr) sq_d.done = 1'b0;

        case (sq_q.st)
            ST_INSTR, ST_POLL_OP: sh_tx = sq_q.op;
            ST_ADDR:              sh_tx = addr_sh[7:0];
            ST_XFER:              sh_tx = sq_q.wr ? sq_q.word[7:0] : 8'h00;
            default:              sh_tx = 8'h00;
        endcase

        if (byte_st && !sq_q.inflight) begin
            sh_start      = 1'b1;
            sq_d.inflight = 1'b1;
        end
        if (fin) sq_d.inflight = 1'b0;

        case (sq_q.st)
            ST_IDLE: begin
                if (launch) begin
                    sq_d.st       = ST_CSOFF;
                    sq_d.sel      = desc_go[GO_CS_LSB +: CSW];
                    sq_d.op       = desc_go[GO_OP_LSB +: 8];
                    sq_d.icnt     = (il_raw > 2'(MAX_ILEN)) ? 2'(MAX_ILEN) : il_raw;
                    sq_d.acnt     = (al_raw > 3'(MAX_ALEN)) ? 3'(MAX_ALEN) : al_raw;
                    sq_d.dcnt     = desc_fmt[FMT_DC_LSB +: 5];
                    sq_d.addr     = desc_addr;
                    sq_d.rem      = desc_len;
                    sq_d.wr       = desc_go[GO_WRITE];
                    sq_d.poll     = (desc_go[2:1] == 2'b10);
                    sq_d.single   = desc_go[GO_SINGLE];
                    sq_d.irq      = desc_go[GO_IRQ];
                    sq_d.pbit     = poll_bit;
                    sq_d.inflight = 1'b0;
                end
            end
            ST_CSOFF: begin
                sq_d.st = sq_q.poll ? ST_POLL_OP
                                    : first_phase(sq_q.icnt, sq_q.acnt, sq_q.dcnt);
            end
            ST_INSTR: begin
                if (fin) begin
                    sq_d.icnt = sq_q.icnt - 2'd1;
                    if (sq_q.icnt == 2'd1)
                        sq_d.st = first_phase(2'd0, sq_q.acnt, sq_q.dcnt);
                end
            end
            ST_ADDR: begin
                if (fin) begin
                    sq_d.acnt = sq_q.acnt - 3'd1;
                    if (sq_q.acnt == 3'd1)
                        sq_d.st = first_phase(2'd0, 3'd0, sq_q.dcnt);
                end
            end
            ST_DUMMY: begin
                if (fin) begin
                    sq_d.dcnt = sq_q.dcnt - 5'd1;
                    if (sq_q.dcnt == 5'd1) sq_d.st = ST_DCHK;
                end
            end
            ST_POLL_OP: begin
                if (fin) sq_d.st = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                if (fin) begin
                    sq_d.status = sh_rx;
                    sq_d.st = (sq_q.single || !sh_rx[sq_q.pbit]) ? ST_DCHK : ST_POLL_OP;
                end
            end
            ST_DCHK: begin
                sq_d.bidx = '0;
                if (sq_q.rem == '0) begin
                    sq_d.st = ST_IDLE;
                    if (sq_q.irq) sq_d.done = 1'b1;
                end else if (sq_q.wr) begin
                    sq_d.st = ST_WRWAIT;
                end else begin
                    sq_d.st   = ST_XFER;
                    sq_d.word = '0;
                end
            end
            ST_WRWAIT: begin
                if (wr_valid) begin
                    sq_d.word = wr_word;
                    sq_d.st   = ST_XFER;
                end
            end
            ST_XFER: begin
                if (fin) begin
                    sq_d.word = {sh_rx, sq_q.word[DATA_W-1:8]};
                    sq_d.bidx = sq_q.bidx + 1'b1;
                    if (sq_q.bidx == BW'(BYTES - 1)) begin
                        sq_d.rem = (sq_q.rem < CNT_W'(BYTES)) ? '0 : sq_q.rem - CNT_W'(BYTES);
                        sq_d.rdv = !sq_q.wr;
                        sq_d.st  = ST_DCHK;
                    end
                end
            end
            default: sq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign busy        = (sq_q.st != ST_IDLE);
    assign cs_act      = (sq_q.st != ST_IDLE) && (sq_q.st != ST_CSOFF);
    assign cs_sel      = sq_q.sel;
    assign wr_ready    = (sq_q.st == ST_WRWAIT);
    assign rd_valid    = sq_q.rdv;
    assign rd_word     = sq_q.word;
    assign status_byte = sq_q.status;
    assign done_flag   = sq_q.done;

    // R2: a launch during a transaction leaves the captured command alone
    p_launch_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && launch) |=> ($stable(sq_q.sel) && $stable(sq_q.op)));
    // R11: remaining count never grows inside a transaction
    p_rem_monotone_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (sq_q.rem <= $past(sq_q.rem)));
    // R12: flag only rises when the transaction ends
    p_done_at_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sq_q.done) |-> !busy);
    // R7: poll loop exits only on a clear bit or single-read
    p_poll_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == ST_DCHK && $past(sq_q.st) == ST_POLL_RD)
            |-> (sq_q.single || !sq_q.status[sq_q.pbit]));

endmodule

// File: rtl/spi_nor_seq.sv
module spi_nor_seq #(
    parameter int NUM_CS = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [31:0]       desc_addr,
    input  logic [31:0]       desc_fmt,
    input  logic [CNT_W-1:0]  desc_len,
    input  logic [31:0]       desc_go,
    input  logic [2:0]        poll_bit,
    input  logic              done_clr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_word,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word,
    output logic [7:0]        status_byte,
    output logic              done_flag,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic           cs_act;
    logic [CSW-1:0] cs_sel;
    logic           sh_start;
    logic [7:0]     sh_tx;
    logic           sh_done;
    logic [7:0]     sh_rx;

    spi_nor_sequencer #(.NUM_CS(NUM_CS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .desc_addr(desc_addr), .desc_fmt(desc_fmt), .desc_len(desc_len),
        .desc_go(desc_go), .poll_bit(poll_bit), .done_clr(done_clr),
        .wr_valid(wr_valid), .wr_word(wr_word), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_word(rd_word), .status_byte(status_byte),
        .done_flag(done_flag), .busy(busy), .cs_act(cs_act), .cs_sel(cs_sel),
        .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx)
    );

    spi_nor_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(miso),
        .sck(sck), .mosi(mosi), .done(sh_done), .rx(sh_rx)
    );

    spi_nor_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
        .act(cs_act), .sel(cs_sel), .cs_n(cs_n)
    );

    // R8: no line is selected outside a transaction
    p_cs_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (~&cs_n) |-> busy);
    // R6: serial clock only toggles inside a transaction
    p_sck_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> busy);
    // R2: at most one line low
    p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

endmodule

// File: tb/tb_spi_nor_seq.sv
module tb_spi_nor_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch = 1'b0;
    logic [31:0] desc_addr = '0, desc_fmt = '0, desc_len = '0, desc_go = '0;
    logic [2:0]  poll_bit = '0;
    logic        done_clr = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_word = '0;
    logic        wr_ready, rd_valid, done_flag, busy, sck, mosi;
    logic [31:0] rd_word;
    logic [7:0]  status_byte;
    logic        miso_r = 1'b0;
    logic [3:0]  cs_n;

    spi_nor_seq dut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .desc_addr(desc_addr),
        .desc_fmt(desc_fmt), .desc_len(desc_len), .desc_go(desc_go),
        .poll_bit(poll_bit), .done_clr(done_clr), .wr_valid(wr_valid),
        .wr_word(wr_word), .wr_ready(wr_ready), .rd_valid(rd_valid),
        .rd_word(rd_word), .status_byte(status_byte), .done_flag(done_flag),
        .busy(busy), .sck(sck), .mosi(mosi), .miso(miso_r), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;

    // ---------------- flash model ----------------
    logic [7:0] log_b [0:127];
    logic [7:0] miso_arr [0:127];
    int nlog = 0;
    int sidx = 0, sb = 0;
    logic [7:0] so = '0, rxs = '0;
    logic cs_any;
    assign cs_any = ~&cs_n;

    always @(posedge cs_any) begin
        sidx = 0; sb = 0; so = miso_arr[0]; miso_r = so[7];
    end
    always @(posedge sck) if (cs_any) begin
        rxs = {rxs[6:0], mosi};
        sb++;
        if (sb == 8) begin
            if (nlog < 128) log_b[nlog] = rxs;
            nlog++; sb = 0; sidx = (sidx + 1) & 127; so = miso_arr[sidx];
        end
    end
    always @(negedge sck) if (cs_any) miso_r = so[7 - sb];

    // R6 monitor
    int viol = 0;
    logic sck_prev = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (sck && sck_prev) viol++;
        if (!busy && sck) viol++;
        sck_prev = sck;
    end

    int cyc = 0;
    always @(posedge clk) cyc++;
    initial begin
        wait (cyc >= WDOG);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] wr_arr [0:15];
    logic [31:0] rd_got [0:15];
    logic [31:0] rd_exp [0:15];
    logic [7:0]  exp_b [0:127];

    function automatic logic [31:0] mkfmt(int il, int al, int dm);
        return {6'b0, 2'(il), 8'(dm), 13'b0, 3'(al)};
    endfunction
    function automatic logic [31:0] mkgo(logic [7:0] op, int cs, bit single, int mode, bit irq);
        return {op, 14'b0, 2'(cs), 4'b0, single, 2'(mode), irq};
    endfunction

    task automatic run_txn(input logic [7:0] op, input logic [31:0] addr, input int il,
                           input int al, input int dm, input int cnt, input int mode,
                           input int cs, input bit single, input bit irq, input int pbit,
                           input int inj, input string tag);
        int ne, hdr, nw, nrd, widx, k, lim;
        bit pend, wr;
        logic [7:0] stv, exp_status;
        logic [3:0] cs_seen;
        wr = (mode == 1) || (mode == 3);
        ne = 0; exp_status = status_byte;
        if (mode == 2) begin
            k = 0;
            while (1) begin
                exp_b[ne++] = op; exp_b[ne++] = 8'h00;
                stv = miso_arr[2*k+1]; k++;
                exp_status = stv;
                if (single || !stv[pbit] || k > 20) break;
            end
        end else begin
            for (int i = 0; i < ((il > 2) ? 2 : il); i++) exp_b[ne++] = op;
            for (int j = ((al > 4) ? 4 : al) - 1; j >= 0; j--) exp_b[ne++] = addr[8*j +: 8];
            for (int i = 0; i < (dm >> 3); i++) exp_b[ne++] = 8'h00;
        end
        hdr = ne;
        nw = (cnt + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            for (int b = 0; b < 4; b++) exp_b[ne++] = wr ? wr_arr[w][8*b +: 8] : 8'h00;
            rd_exp[w] = {miso_arr[hdr+4*w+3], miso_arr[hdr+4*w+2], miso_arr[hdr+4*w+1], miso_arr[hdr+4*w]};
        end
        // clear flag (R12) and start
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        nlog = 0; cs_seen = '0; nrd = 0; widx = 0; pend = 0;
        wr_word = wr_arr[0]; wr_valid = 1'b1;
        desc_addr = addr; desc_fmt = mkfmt(il, al, dm); desc_len = cnt;
        desc_go = mkgo(op, cs, single, mode, irq); poll_bit = 3'(pbit);
        launch = 1'b1;
        @(negedge clk); launch = 1'b0;
        chk(busy == 1'b1, "R2 busy after launch", {31'b0, busy}, 32'd1);
        lim = 0;
        while (1) begin
            @(negedge clk);
            lim++;
            launch = 1'b0;
            cs_seen |= ~cs_n;
            if (rd_valid && nrd < 16) rd_got[nrd++] = rd_word;
            if (!busy || lim > 20000) break;
            if (pend) begin widx++; wr_word = wr_arr[widx & 15]; pend = 0; end
            if (wr_ready) pend = 1;
            if (inj != 0 && lim == inj) begin
                desc_go = mkgo(8'h5A, (cs + 1) % 4, 1'b0, 1, 1'b1);
                desc_len = 32'd40;
                launch = 1'b1;
            end
        end
        wr_valid = 1'b0;
        chk(nlog == ne, {tag, " byte count"}, nlog, ne);
        begin
            int bad = -1;
            for (int i = 0; i < ne && i < nlog; i++) if (bad < 0 && log_b[i] !== exp_b[i]) bad = i;
            chk(bad < 0, {tag, " byte stream"}, (bad < 0) ? 0 : log_b[bad], (bad < 0) ? 0 : exp_b[bad]);
        end
        chk(cs_seen == 4'(1 << cs), "R2 chip-select lines", cs_seen, 4'(1 << cs));
        chk(!busy && cs_n == 4'hF, "R8 release", {busy, cs_n}, {1'b0, 4'hF});
        chk(done_flag == irq, "R12 done flag", done_flag, irq);
        if (!wr && mode != 2) begin
            chk(nrd == nw, "R11 word count", nrd, nw);
            for (int w = 0; w < nw && w < nrd; w++)
                chk(rd_got[w] == rd_exp[w], "R10 read word", rd_got[w], rd_exp[w]);
        end
        if (mode == 2) chk(status_byte == exp_status, "R7 status byte", status_byte, exp_status);
        if (inj != 0) begin
            repeat (6) @(negedge clk);
            chk(!busy && cs_n == 4'hF, "R2 ignored launch left no work", {busy, cs_n}, {1'b0, 4'hF});
        end
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        for (int i = 0; i < 128; i++) miso_arr[i] = 8'(i * 37 + 11);
        for (int i = 0; i < 16; i++) wr_arr[i] = 32'hA0B0C0D0 + 32'(i * 32'h01010101);
        repeat (3) @(negedge clk);
        chk(cs_n == 4'hF && !sck && !busy, "R1 reset lines", {sck, busy, cs_n}, {2'b0, 4'hF});
        chk(!done_flag && !wr_ready && !rd_valid && status_byte == 0, "R1 reset outputs",
            {done_flag, wr_ready, rd_valid, status_byte}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 4'hF && !busy, "R1 after reset release", {busy, cs_n}, {1'b0, 4'hF});

        // R4 R5: 1 opcode, 3 address bytes, 8 dummy cycles
        run_txn(8'h0B, 32'h0012_3456, 1, 3, 8, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R3 caps and R5 truncation: il=3->2, al=7->4, dummy 0x17->2
        run_txn(8'h9F, 32'hDEAD_BEEF, 3, 7, 8'h17, 0, 0, 2, 0, 1, 0, 0, "R3");
        // R8: nothing to send at all
        run_txn(8'h06, 32'h0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 0, "R8");
        // R9 R11: write 6 bytes -> 2 words
        run_txn(8'h02, 32'h0000_1000, 1, 3, 0, 6, 1, 1, 0, 1, 0, 0, "R9");
        // R12: flag clears on request
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk(done_flag == 1'b0, "R12 clear", done_flag, 0);
        // R10: read 8 bytes
        run_txn(8'h03, 32'h0000_2040, 1, 3, 0, 8, 0, 0, 0, 0, 0, 0, "R10");
        // R11: count 5 -> 2 words
        run_txn(8'h0B, 32'h0000_0080, 1, 3, 8, 5, 0, 2, 0, 1, 0, 0, "R11");
        // R7: poll with bit 2 busy twice
        miso_arr[1] = 8'h04; miso_arr[3] = 8'h06; miso_arr[5] = 8'h03;
        run_txn(8'h05, 32'h0, 1, 0, 0, 0, 2, 1, 0, 1, 2, 0, "R7");
        // R7: single read with busy bit set
        miso_arr[1] = 8'h81;
        run_txn(8'h05, 32'h0, 1, 0, 0, 0, 2, 3, 1, 0, 7, 0, "R7");
        // R2: launch mid-transaction ignored
        run_txn(8'h02, 32'h0000_0300, 1, 3, 0, 4, 1, 1, 0, 0, 0, 40, "R2");

        // constrained random mix
        for (int t = 0; t < 24; t++) begin
            int mode;
            for (int i = 0; i < 128; i++) miso_arr[i] = 8'($urandom);
            for (int i = 0; i < 16; i++) wr_arr[i] = $urandom;
            mode = ($urandom % 8 == 0) ? 2 : int'($urandom % 2);
            run_txn(8'($urandom), $urandom, int'($urandom % 4), int'($urandom % 8),
                    int'($urandom % 64), int'($urandom % 17), mode, int'($urandom % 4),
                    1'($urandom), 1'($urandom), int'($urandom % 8), 0,
                    (mode == 1) ? "R9" : "R5");
        end
        chk(viol == 0, "R6 clock shape", viol, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule